// File: doc/BRIEF.md
# Mirrored-Window Output Control Registers

This block is a write-only peripheral on a 16-bit bus with byte strobes. It takes bus writes and turns them into registered control lines for the board around it. Those lines are joypad port outputs, a memory-card bank select, LED and marquee display latches, serial clock pins for a real-time clock, and sink/release control for two coin counters and two coin lockouts. Every register answers across a wide mirrored window. The decoder compares only the address bits that the register's own decode mask enables. Masked-off bits can take any value.

The display path has two stages. Software first writes a byte into a shared data register. It then toggles strobe bits in a latch-control register. A strobe bit that goes from 1 to 0 copies the shared byte into that strobe's output latch. The coin and lockout lines work differently. The address alone drives them: one address range makes a line sink current and the other releases it, whatever the data.

Top module: `iox_outregs`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every output is 0. This covers the joypad nibbles, card bank, all three display latches, all RTC pins and all four coin lines.
- R2: A register is hit when `((byte_address ^ base) & mask) == 0` over byte-address bits 23..1. Address bit 0 is given by `bus_lds`. Any value on masked-off bits selects the same register. The masks are $FE0071 for the joypad and card registers and $FE00F1 for the others. At most one register is hit per write.
- R3: A write takes effect only when `bus_we` and `bus_lds` are both high. A cycle with `bus_lds` low, with only `bus_uds` high, or with `bus_we` low changes no output.
- R4: A write at base $380001 loads `bus_wdata[3:0]` into `joy_p1_out` and `bus_wdata[7:4]` into `joy_p2_out`.
- R5: A write at base $380011 loads `bus_wdata[7:0]` into `card_bank`.
- R6: A write at base $380041 stores `bus_wdata[7:0]` as the shared display byte. It does not change any output by itself.
- R7: A write at base $380031 loads strobe bits `bus_wdata[3]` (marquee), `bus_wdata[4]` (LED1) and `bus_wdata[5]` (LED2). A bit that was 1 and is now written 0 copies the shared display byte into its latch. The latch output changes on the clock edge that takes the write.
- R8: A strobe bit that stays 0, stays 1, or rises leaves its latch unchanged.
- R9: Any write at base $380061, whatever its data, releases (drives 0) `coin_sink[n]`. Here n is byte-address bits 2..1: 0 is counter 1, 1 is counter 2, 2 is lockout 1 and 3 is lockout 2.
- R10: Any write at base $3800E1, whatever its data, makes `coin_sink[n]` sink (drive 1). The channel n is chosen the same way as in R9.
- R11: A write at base $380051 drives `rtc_din` from `bus_wdata[0]`, `rtc_clk` from `bus_wdata[1]` and `rtc_stb` from `bus_wdata[2]`.
- R12: A write whose address differs from every base on some enabled mask bit changes no output. Examples are a differing bit 23..17, or a low byte that matches no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 23 | Byte address bits 23..1 |
| bus_wdata | input | 16 | Write data; low byte used |
| bus_uds | input | 1 | Upper (even) byte strobe |
| bus_lds | input | 1 | Lower (odd) byte strobe |
| bus_we | input | 1 | Write strobe |
| joy_p1_out | output | 4 | Joypad port 1 outputs |
| joy_p2_out | output | 4 | Joypad port 2 outputs |
| card_bank | output | 8 | Memory-card bank select |
| led_marquee | output | 8 | Marquee latch |
| led1 | output | 8 | LED1 latch |
| led2 | output | 8 | LED2 latch |
| rtc_din | output | 1 | RTC serial data in |
| rtc_clk | output | 1 | RTC serial clock |
| rtc_stb | output | 1 | RTC strobe |
| coin_sink | output | 4 | Per-line sink (1) or release (0) |

## Verification
Every odd low-byte offset is written under four upper-address patterns. Two patterns are mirrors inside the window, and they show that masked-off bits are ignored. The other two differ on enabled bits, and they show that nothing outside the window responds. Pseudo-random data reaches the latch-control register with every mix of strobe transitions, which separates a falling edge from a held level or a rising edge. The same full sweep is then repeated with only the upper strobe and with the write strobe low; neither may change any output. A directed sequence then checks hold-at-1, hold-at-0, rise and fall one at a time. Coin writes use all-ones and all-zeros data, which shows that only the address picks the set/release action.

// File: rtl/iox_pkg.sv
package iox_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned NREG   = 7;

  typedef enum logic [2:0] {
    RG_JOY   = 3'd0,
    RG_CARD  = 3'd1,
    RG_LATCH = 3'd2,
    RG_LDATA = 3'd3,
    RG_RTC   = 3'd4,
    RG_CCLR  = 3'd5,
    RG_CSET  = 3'd6
  } reg_e;

  function automatic logic [ADDR_W-1:0] reg_base(input int unsigned idx);
    case (idx)
      0:       return 24'h380001;
      1:       return 24'h380011;
      2:       return 24'h380031;
      3:       return 24'h380041;
      4:       return 24'h380051;
      5:       return 24'h380061;
      default: return 24'h3800E1;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] reg_mask(input int unsigned idx);
    case (idx)
      0, 1:    return 24'hFE0071;
      default: return 24'hFE00F1;
    endcase
  endfunction
endpackage

// File: rtl/iox_decode.sv
module iox_decode
  import iox_pkg::*;
(
  input  logic [ADDR_W-2:0] addr,
  input  logic              wr_ok,
  output logic [NREG-1:0]   hit
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] BASE = reg_base(g);
    localparam logic [ADDR_W-1:0] MASK = reg_mask(g);
    assign hit[g] = wr_ok && (((addr ^ BASE[ADDR_W-1:1]) & MASK[ADDR_W-1:1]) == '0);
  end
endmodule

// File: rtl/iox_led_latch.sv
module iox_led_latch #(
  parameter int unsigned NLAT = 3,
  parameter int unsigned DW   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DW-1:0]            ldata,
  input  logic                     ctrl_we,
  input  logic [NLAT-1:0]          ctrl_new,
  output logic [NLAT-1:0][DW-1:0]  lat_q
);
  logic [NLAT-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_new;
  end

  for (genvar g = 0; g < NLAT; g++) begin : g_lat
    logic fall;
    assign fall = ctrl_we && ctrl_q[g] && !ctrl_new[g];

    always_ff @(posedge clk) begin
      if (rst)       lat_q[g] <= '0;
      else if (fall) lat_q[g] <= ldata;
    end

    p_capture_r7: assert property (@(posedge clk) disable iff (rst)
      (ctrl_we && ctrl_q[g] && !ctrl_new[g]) |=> (lat_q[g] == $past(ldata)));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!ctrl_we || !ctrl_q[g] || ctrl_new[g]) |=> $stable(lat_q[g]));
  end
endmodule

// File: rtl/iox_coin.sv
module iox_coin #(
  parameter int unsigned NCH = 4,
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           set_hit,
  input  logic           clr_hit,
  input  logic [CW-1:0]  chan,
  output logic [NCH-1:0] sink
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)                                 sink[g] <= 1'b0;
      else if (set_hit && chan == CW'(g))      sink[g] <= 1'b1;
      else if (clr_hit && chan == CW'(g))      sink[g] <= 1'b0;
    end
  end

  p_coin_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !(set_hit || clr_hit) |=> $stable(sink));

  p_coin_set_r10: assert property (@(posedge clk) disable iff (rst)
    set_hit |=> sink[$past(chan)]);

  p_coin_clr_r9: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> !sink[$past(chan)]);
endmodule

// File: rtl/iox_outregs.sv
module iox_outregs
  import iox_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned NLAT    = 3,
  parameter int unsigned STB_LSB = 3,
  parameter int unsigned NCOIN   = 4,
  parameter int unsigned RTC_W   = 3,
  localparam int unsigned NIB    = DW / 2,
  localparam int unsigned CW     = $clog2(NCOIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-2:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_uds,
  input  logic              bus_lds,
  input  logic              bus_we,
  output logic [NIB-1:0]    joy_p1_out,
  output logic [NIB-1:0]    joy_p2_out,
  output logic [DW-1:0]     card_bank,
  output logic [DW-1:0]     led_marquee,
  output logic [DW-1:0]     led1,
  output logic [DW-1:0]     led2,
  output logic              rtc_din,
  output logic              rtc_clk,
  output logic              rtc_stb,
  output logic [NCOIN-1:0]  coin_sink
);
  logic [NREG-1:0]         hit;
  logic                    wr_ok;
  logic [DW-1:0]           wbyte;
  logic [DW-1:0]           joy_q, card_q, ldata_q;
  logic [RTC_W-1:0]        rtc_q;
  logic [NLAT-1:0][DW-1:0] lat;
  logic                    unused_ok;

  assign wr_ok     = bus_we && bus_lds;
  assign wbyte     = bus_wdata[DW-1:0];
  assign unused_ok = ^{bus_uds, bus_wdata[15:DW]};

  iox_decode i_dec (.addr(bus_addr), .wr_ok(wr_ok), .hit(hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      joy_q   <= '0;
      card_q  <= '0;
      ldata_q <= '0;
      rtc_q   <= '0;
    end else begin
      if (hit[RG_JOY])   joy_q   <= wbyte;
      if (hit[RG_CARD])  card_q  <= wbyte;
      if (hit[RG_LDATA]) ldata_q <= wbyte;
      if (hit[RG_RTC])   rtc_q   <= wbyte[RTC_W-1:0];
    end
  end

  iox_led_latch #(.NLAT(NLAT), .DW(DW)) i_lat (
    .clk(clk), .rst(rst), .ldata(ldata_q),
    .ctrl_we(hit[RG_LATCH]),
    .ctrl_new(bus_wdata[STB_LSB +: NLAT]),
    .lat_q(lat)
  );

  iox_coin #(.NCH(NCOIN)) i_coin (
    .clk(clk), .rst(rst),
    .set_hit(hit[RG_CSET]), .clr_hit(hit[RG_CCLR]),
    .chan(bus_addr[CW-1:0]),
    .sink(coin_sink)
  );

  assign joy_p1_out  = joy_q[NIB-1:0];
  assign joy_p2_out  = joy_q[DW-1:NIB];
  assign card_bank   = card_q;
  assign led_marquee = lat[0];
  assign led1        = lat[1];
  assign led2        = lat[2];
  assign rtc_din     = rtc_q[0];
  assign rtc_clk     = rtc_q[1];
  assign rtc_stb     = rtc_q[2];

  p_single_hit_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));

  p_strobe_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_lds) |=> $stable({joy_q, card_q, ldata_q, rtc_q, lat, coin_sink}));

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (joy_q == '0 && card_q == '0 && coin_sink == '0 && rtc_q == '0));
endmodule

// File: tb/test_iox_outregs.sv
module test_iox_outregs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [22:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_uds = 1'b0, bus_lds = 1'b0, bus_we = 1'b0;
  logic [3:0]  joy_p1_out, joy_p2_out;
  logic [7:0]  card_bank, led_marquee, led1, led2;
  logic        rtc_din, rtc_clk, rtc_stb;
  logic [3:0]  coin_sink;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0]  e_joy = 0, e_card = 0, e_ld = 0, e_mq = 0, e_l1 = 0, e_l2 = 0;
  logic [2:0]  e_ctl = 0, e_rtc = 0;
  logic [3:0]  e_coin = 0;
  logic [15:0] rnd = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  iox_outregs i_iox_outregs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_uds(bus_uds), .bus_lds(bus_lds), .bus_we(bus_we),
    .joy_p1_out(joy_p1_out), .joy_p2_out(joy_p2_out), .card_bank(card_bank),
    .led_marquee(led_marquee), .led1(led1), .led2(led2),
    .rtc_din(rtc_din), .rtc_clk(rtc_clk), .rtc_stb(rtc_stb), .coin_sink(coin_sink)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit mhit(input logic [23:0] a, input logic [23:0] b, input logic [23:0] m);
    return ((a ^ b) & m & 24'hFFFFFE) == 24'h0;
  endfunction

  task automatic compare_all();
    chk("R4 joypad", {joy_p2_out, joy_p1_out}, e_joy);
    chk("R5 card bank", card_bank, e_card);
    chk("R7 marquee latch", led_marquee, e_mq);
    chk("R7 led1 latch", led1, e_l1);
    chk("R7 led2 latch", led2, e_l2);
    chk("R11 rtc pins", {rtc_stb, rtc_clk, rtc_din}, e_rtc);
    chk("R9/R10 coin lines", coin_sink, e_coin);
  endtask

  task automatic do_write(input logic [23:0] a, input logic [15:0] d,
                          input logic lds, input logic uds, input logic we);
    logic [2:0] nw, fall;
    @(negedge clk);
    bus_addr = a[23:1]; bus_wdata = d; bus_lds = lds; bus_uds = uds; bus_we = we;
    if (we && lds) begin
      if (mhit(a, 24'h380001, 24'hFE0071)) e_joy  = d[7:0];
      if (mhit(a, 24'h380011, 24'hFE0071)) e_card = d[7:0];
      if (mhit(a, 24'h380041, 24'hFE00F1)) e_ld   = d[7:0];
      if (mhit(a, 24'h380051, 24'hFE00F1)) e_rtc  = d[2:0];
      if (mhit(a, 24'h380031, 24'hFE00F1)) begin
        nw = d[5:3];
        fall = e_ctl & ~nw;
        if (fall[0]) e_mq = e_ld;
        if (fall[1]) e_l1 = e_ld;
        if (fall[2]) e_l2 = e_ld;
        e_ctl = nw;
      end
      if (mhit(a, 24'h380061, 24'hFE00F1)) e_coin[a[2:1]] = 1'b0;
      if (mhit(a, 24'h3800E1, 24'hFE00F1)) e_coin[a[2:1]] = 1'b1;
    end
    @(negedge clk);
    bus_we = 0; bus_lds = 0; bus_uds = 0;
    compare_all();
  endtask

  function automatic logic [15:0] step(input logic [15:0] x);
    logic [15:0] y;
    y = x ^ (x << 7);
    y = y ^ (y >> 9);
    y = y ^ (y << 8);
    return y;
  endfunction

  initial begin
    logic [23:0] hi [4];
    hi[0] = 24'h380000; hi[1] = 24'h39A500;  // mirrors inside the window (R2)
    hi[2] = 24'h3A0000; hi[3] = 24'h780000;  // enabled bits differ (R12)
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset joypad", {joy_p2_out, joy_p1_out}, 0);
    chk("R1 reset latches", {led_marquee, led1, led2, card_bank}, 0);
    chk("R1 reset rtc/coin", {rtc_stb, rtc_clk, rtc_din, coin_sink}, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", {joy_p1_out, joy_p2_out, card_bank, coin_sink}, 0);

    // R2/R12 sweep, all odd low-byte offsets, accepted writes
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 128; i++) begin
        rnd = step(rnd);
        do_write(hi[p] | 24'(2*i+1), rnd, 1'b1, 1'b0, 1'b1);
      end
    // R3: upper strobe only, then write strobe low
    for (int i = 0; i < 128; i++) begin
      rnd = step(rnd);
      do_write(24'h380000 | 24'(2*i+1), rnd, 1'b0, 1'b1, 1'b1);
    end
    for (int i = 0; i < 128; i++) begin
      rnd = step(rnd);
      do_write(24'h380000 | 24'(2*i+1), rnd, 1'b1, 1'b1, 1'b0);
    end

    // R6/R7/R8 directed latch transitions
    do_write(24'h380031, 16'h0000, 1, 0, 1);
    do_write(24'h380041, 16'h005A, 1, 0, 1);
    chk("R6 data alone no latch change", {led_marquee, led1, led2}, {e_mq, e_l1, e_l2});
    do_write(24'h380031, 16'h0038, 1, 0, 1);   // rise: no capture
    chk("R8 rise no capture", led1, e_l1);
    do_write(24'h380041, 16'h00C3, 1, 0, 1);
    do_write(24'h380031, 16'h0038, 1, 0, 1);   // hold at 1
    chk("R8 hold high no capture", led2, e_l2);
    do_write(24'h380031, 16'h0028, 1, 0, 1);   // LED1 falls
    chk("R7 led1 captured", led1, 8'hC3);
    chk("R8 others untouched", {led_marquee, led2}, {e_mq, e_l2});
    do_write(24'h380031, 16'h0000, 1, 0, 1);   // marquee and LED2 fall
    chk("R7 marquee+led2 captured", {led_marquee, led2}, 16'hC3C3);

    // R9/R10: data ignored for coin lines
    for (int c = 0; c < 4; c++) do_write(24'h3800E1 | 24'(2*c), 16'h0000, 1, 0, 1);
    chk("R10 all sinking", coin_sink, 4'hF);
    do_write(24'h380065, 16'hFFFF, 1, 0, 1);
    chk("R9 lockout1 released", coin_sink, 4'b1011);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule